// File: doc/BRIEF.md
# Receive Frame Field Compare Unit

This block sits on the receive side of an Ethernet port and watches a frame that arrives one byte per valid cycle. It holds a small pool of compare entries. Each entry looks for two or four bytes at a programmed offset and tests them against a programmed value. The offset is counted from one of four anchor points in the frame: the first byte of the frame, the byte after the last EtherType, the byte after the IP header, or the byte after the start of the L4 header. An upstream header locator raises a strobe on the byte where each anchor falls. This block does not build that locator; it only consumes its strobes.

Each entry is checked byte by byte as the frame streams past. The result is latched as it goes, so the frame is never buffered. When the byte that ends the frame is accepted, the block presents one match flag per entry, together with a single-cycle valid pulse. A rule engine further downstream selects entries by index and uses the flags for filtering or queue steering. Software loads the entries through a simple write port. Each entry has a value/mask word and a control word, and entries are written between frames.

Top module: `rfc_field_cmp`

## Requirements
- R1: Each entry has a 32-bit value word (written when `cfg_sel`=0) and a control word (written when `cfg_sel`=1), loaded at `cfg_idx` when `cfg_we` is high. Both words reset to zero. An entry left at its reset state therefore matches any frame of two or more bytes.
- R2: With control bit 9 clear (16-bit mode), the byte at offset+0 ANDed with value[7:0] must equal value[23:16]. The byte at offset+1 ANDed with value[15:8] must equal value[31:24]. A value bit that lies outside the mask can never match.
- R3: With control bit 9 set (32-bit mode), no mask is applied. The bytes at offset+0, +1, +2 and +3 must equal value[7:0], [15:8], [23:16] and [31:24] respectively.
- R4: Control bits [8:7] choose the anchor: 0 is the frame's first byte, 1 is the byte where `anc_l2_stb` is high, 2 is the byte where `anc_l3_stb` is high, and 3 is the byte where `anc_l4_stb` is high. The anchor byte is offset 0.
- R5: Control bits [6:0] give the offset, from 0 to 127 bytes after the anchor.
- R6: Only the first strobe of the selected anchor within a frame counts. Later strobes of that anchor in the same frame do not move the compare window.
- R7: If the frame ends before every required byte has been seen, the entry reports no match. This covers a selected anchor that never appears, and it covers a single-byte frame.
- R8: A frame's first byte (`rx_sof` with `rx_valid`) clears all per-entry progress. This includes an earlier mismatch and an earlier truncated compare.
- R9: `match_vld` is high for exactly the one cycle after the edge that accepts a byte with `rx_eof`. `match_vec` carries the per-entry flags in that cycle and is zero in every other cycle.
- R10: Entries are evaluated independently and at the same time. Bit i of `match_vec` belongs to entry i.
- R11: Cycles with `rx_valid` low are ignored. They neither advance the byte position nor affect any compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Entry write enable |
| cfg_sel | input | 1 | 0 writes the value word, 1 writes the control word |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_wdata | input | 32 | Write data |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | This byte is the first byte of a frame |
| rx_eof | input | 1 | This byte is the last byte of a frame |
| anc_l2_stb | input | 1 | This byte follows the last EtherType |
| anc_l3_stb | input | 1 | This byte follows the IP header |
| anc_l4_stb | input | 1 | This byte follows the start of the L4 header |
| match_vld | output | 1 | Match flags valid for one cycle after the frame ends |
| match_vec | output | N_ENTRIES | Per-entry match flags |

## Verification
The match flags come from a single register stage. They appear on the clock edge that accepts the byte carrying `rx_eof`, and nothing changes on the edges before it. The bench drives inputs on falling edges. After the last byte it reads `match_vld` and the flags at the very next falling edge. It then reads them again one falling edge later to confirm that the pulse has ended. Write-port updates take effect at the edge that accepts the write. Every frame starts at least two cycles after the last configuration write, so no compare overlaps an update.

// File: rtl/rfc_pkg.sv
// Package: shared types for the receive frame field compare unit.
// Holds the control-word layout and the anchor encoding that every
// entry decodes. Assumes a 32-bit configuration word.
package rfc_pkg;

    localparam int CFG_W        = 32;
    localparam int OFF_W        = 7;
    localparam int ANC_LSB      = 7;
    localparam int WIDE_BIT     = 9;
    localparam int POS_W        = 8;
    localparam int N_ANCHORS    = 4;

    typedef enum logic [1:0] {
        ANC_FRAME = 2'd0,
        ANC_L2    = 2'd1,
        ANC_L3    = 2'd2,
        ANC_L4    = 2'd3
    } anchor_e;

    typedef struct packed {
        logic             wide;
        anchor_e          anc;
        logic [OFF_W-1:0] off;
    } cmp_ctrl_t;

    // Extract the used fields from a raw control word.
    function automatic cmp_ctrl_t ctrl_from_word(input logic [CFG_W-1:0] w);
        cmp_ctrl_t c;
        c.off  = w[OFF_W-1:0];
        c.anc  = anchor_e'(w[ANC_LSB+1:ANC_LSB]);
        c.wide = w[WIDE_BIT];
        return c;
    endfunction

endpackage

// File: rtl/rfc_cfg_bank.sv
// Module: rfc_cfg_bank
// Stores the value/mask word and the decoded control fields of every
// compare entry. Assumes software writes entries between frames; a
// write lands at the clock edge where cfg_we is sampled high.
module rfc_cfg_bank
    import rfc_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic                            sel,
    input  logic [IDX_W-1:0]                idx,
    input  logic [CFG_W-1:0]                wdata,
    output logic [N_ENTRIES-1:0][CFG_W-1:0] value_o,
    output cmp_ctrl_t [N_ENTRIES-1:0]       ctrl_o
);

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
        logic hit_w;
        assign hit_w = we && (idx == IDX_W'(i));

        // Hold one entry's words; clear on reset, load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                value_o[i] <= '0;
                ctrl_o[i]  <= '0;
            end else if (hit_w) begin
                if (sel) begin
                    ctrl_o[i] <= ctrl_from_word(wdata);
                end else begin
                    value_o[i] <= wdata;
                end
            end
        end
    end

endmodule

// File: rtl/rfc_anchor_gen.sv
// Module: rfc_anchor_gen
// Turns the byte-valid, start-of-frame and locator strobes into a
// per-byte anchor vector indexed by anchor code. Assumes the locator
// raises each strobe on the same cycle as the anchor byte itself.
module rfc_anchor_gen
    import rfc_pkg::*;
(
    input  logic                 byte_vld,
    input  logic                 sof,
    input  logic                 l2_stb,
    input  logic                 l3_stb,
    input  logic                 l4_stb,
    output logic [N_ANCHORS-1:0] anc_hit_o,
    output logic                 sof_o
);

    // Gate every anchor with byte-valid so idle cycles carry no anchor.
    always_comb begin
        anc_hit_o           = '0;
        anc_hit_o[ANC_FRAME] = byte_vld && sof;
        anc_hit_o[ANC_L2]    = byte_vld && l2_stb;
        anc_hit_o[ANC_L3]    = byte_vld && l3_stb;
        anc_hit_o[ANC_L4]    = byte_vld && l4_stb;
        sof_o                = byte_vld && sof;
    end

endmodule

// File: rtl/rfc_entry.sv
// Module: rfc_entry
// One compare entry. Once the first strobe of its chosen anchor arrives,
// it counts the bytes, checks each byte that falls in its 2- or 4-byte
// window as it passes, and records which window bytes were seen and
// whether any failed. hit_o is the verdict that includes the current
// byte; the parent samples it on the end-of-frame byte. Assumes sof
// arrives together with byte_vld.
module rfc_entry
    import rfc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 byte_vld,
    input  logic [7:0]           byte_data,
    input  logic                 sof,
    input  logic [N_ANCHORS-1:0] anc_hit,
    input  logic [CFG_W-1:0]     value,
    input  cmp_ctrl_t            ctrl,
    output logic                 hit_o
);

    logic             armed_q;
    logic [POS_W-1:0] pos_q;
    logic [3:0]       seen_q;
    logic             bad_q;

    logic             armed_e;
    logic [3:0]       seen_e;
    logic             bad_e;
    logic             take;
    logic             live;
    logic [POS_W-1:0] cur;
    logic [POS_W:0]   rel;
    logic [2:0]       nbytes;
    logic             in_win;
    logic [1:0]       k;
    logic [7:0]       exp_b;
    logic [7:0]       msk_b;
    logic             byte_ok;
    logic [3:0]       seen_n;
    logic             bad_n;
    logic [3:0]       need;
    logic [POS_W-1:0] pos_n;

    // Start-of-frame view of the progress state: a new frame starts clean.
    always_comb begin
        armed_e = sof ? 1'b0 : armed_q;
        seen_e  = sof ? 4'b0 : seen_q;
        bad_e   = sof ? 1'b0 : bad_q;
    end

    // Locate the current byte relative to the anchor and the window.
    always_comb begin
        take   = anc_hit[ctrl.anc] && !armed_e;
        live   = armed_e || take;
        cur    = take ? '0 : pos_q;
        rel    = {1'b0, cur} - {{(POS_W+1-OFF_W){1'b0}}, ctrl.off};
        nbytes = ctrl.wide ? 3'd4 : 3'd2;
        in_win = live && !rel[POS_W] && (rel[POS_W-1:0] < {{(POS_W-3){1'b0}}, nbytes});
        k      = rel[1:0];
        pos_n  = (cur == {POS_W{1'b1}}) ? cur : cur + 1'b1;
    end

    // Pick the expected byte and mask for the window slot in use.
    always_comb begin
        if (ctrl.wide) begin
            exp_b = value[{k, 3'b000} +: 8];
            msk_b = 8'hFF;
        end else if (k[0]) begin
            exp_b = value[31:24];
            msk_b = value[15:8];
        end else begin
            exp_b = value[23:16];
            msk_b = value[7:0];
        end
        byte_ok = ((byte_data & msk_b) == exp_b);
    end

    // Fold the current byte into the seen/failed record and form the verdict.
    always_comb begin
        seen_n = seen_e | (in_win ? (4'b0001 << k) : 4'b0000);
        bad_n  = bad_e || (in_win && !byte_ok);
        need   = ctrl.wide ? 4'b1111 : 4'b0011;
        hit_o  = ((seen_n & need) == need) && !bad_n;
    end

    // Advance the progress state on every accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            pos_q   <= '0;
            seen_q  <= '0;
            bad_q   <= 1'b0;
        end else if (byte_vld) begin
            armed_q <= live;
            pos_q   <= live ? pos_n : '0;
            seen_q  <= seen_n;
            bad_q   <= bad_n;
        end
    end

endmodule

// File: rtl/rfc_field_cmp.sv
// Module: rfc_field_cmp (top)
// Receive frame field compare unit: a pool of N_ENTRIES compare entries
// evaluated in parallel against a byte stream. The per-entry flags are
// registered on the end-of-frame byte and shown for one cycle. Assumes
// frames are delimited by rx_sof/rx_eof on valid bytes and that entries
// are reprogrammed only between frames.
module rfc_field_cmp
    import rfc_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 cfg_sel,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_data,
    input  logic                 rx_sof,
    input  logic                 rx_eof,
    input  logic                 anc_l2_stb,
    input  logic                 anc_l3_stb,
    input  logic                 anc_l4_stb,
    output logic                 match_vld,
    output logic [N_ENTRIES-1:0] match_vec
);

    logic [N_ENTRIES-1:0][CFG_W-1:0] ent_value;
    cmp_ctrl_t [N_ENTRIES-1:0]       ent_ctrl;
    logic [N_ANCHORS-1:0]            anc_hit;
    logic                            sof_g;
    logic [N_ENTRIES-1:0]            ent_hit;
    logic                            frame_end;

    rfc_cfg_bank #(
        .N_ENTRIES (N_ENTRIES),
        .IDX_W     (IDX_W)
    ) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .idx     (cfg_idx),
        .wdata   (cfg_wdata),
        .value_o (ent_value),
        .ctrl_o  (ent_ctrl)
    );

    rfc_anchor_gen anc_i (
        .byte_vld  (rx_valid),
        .sof       (rx_sof),
        .l2_stb    (anc_l2_stb),
        .l3_stb    (anc_l3_stb),
        .l4_stb    (anc_l4_stb),
        .anc_hit_o (anc_hit),
        .sof_o     (sof_g)
    );

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
        rfc_entry ent_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .byte_vld  (rx_valid),
            .byte_data (rx_data),
            .sof       (sof_g),
            .anc_hit   (anc_hit),
            .value     (ent_value[i]),
            .ctrl      (ent_ctrl[i]),
            .hit_o     (ent_hit[i])
        );
    end

    assign frame_end = rx_valid && rx_eof;

    // Register the flags on the end-of-frame byte; hold them low otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_vld <= 1'b0;
            match_vec <= '0;
        end else begin
            match_vld <= frame_end;
            match_vec <= frame_end ? ent_hit : '0;
        end
    end

endmodule

// File: rtl/rfc_field_cmp_chk.sv
// Module: rfc_field_cmp_chk
// Port-level properties of the compare unit, attached by bind.
module rfc_field_cmp_chk #(
    parameter int N_ENTRIES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_valid,
    input logic                 rx_sof,
    input logic                 rx_eof,
    input logic                 match_vld,
    input logic [N_ENTRIES-1:0] match_vec
);

    AST_VLD_FOLLOWS_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_eof) |=> match_vld); // R9

    AST_NO_STRAY_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_eof) |=> !match_vld); // R9

    AST_VEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !match_vld |-> (match_vec == '0)); // R9

    AST_SINGLE_BYTE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_sof && rx_eof) |=> (match_vec == '0)); // R7

endmodule

bind rfc_field_cmp rfc_field_cmp_chk #(.N_ENTRIES(N_ENTRIES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_sof    (rx_sof),
    .rx_eof    (rx_eof),
    .match_vld (match_vld),
    .match_vec (match_vec)
);

// File: tb/rfc_field_cmp_tb_top.sv
// Bench for rfc_field_cmp. Frame byte p carries 8'h40 + p. The locator
// strobes sit at bytes 14 (L2), 20 (L3) and 30 (L4) unless a test says
// otherwise.
module rfc_field_cmp_tb_top;

    localparam int N = 8;

    typedef struct packed {
        logic [9:0]  ctrl;
        logic [31:0] val;
        logic [7:0]  len;
        logic        anc;
        logic        exp;
    } tv_t;

    localparam tv_t TV [16] = '{
        '{10'h005, 32'h4645FFFF, 8'd40,  1'b1, 1'b1},  // R2 plain 16-bit
        '{10'h005, 32'h4745FFFF, 8'd40,  1'b1, 1'b0},  // R2 byte1 wrong
        '{10'h005, 32'h4605FF0F, 8'd40,  1'b1, 1'b1},  // R2 mask on byte0
        '{10'h005, 32'h4645FF0F, 8'd40,  1'b1, 1'b0},  // R2 value outside mask
        '{10'h20A, 32'h4D4C4B4A, 8'd40,  1'b1, 1'b1},  // R3 32-bit
        '{10'h20A, 32'h4E4C4B4A, 8'd40,  1'b1, 1'b0},  // R3 top byte wrong
        '{10'h082, 32'h5150FFFF, 8'd40,  1'b1, 1'b1},  // R4 L2 anchor
        '{10'h300, 32'h57565554, 8'd40,  1'b1, 1'b1},  // R4 L3 anchor
        '{10'h184, 32'h6362FFFF, 8'd40,  1'b1, 1'b1},  // R4 L4 anchor
        '{10'h184, 32'h6362FFFF, 8'd35,  1'b1, 1'b0},  // R7 one byte short
        '{10'h184, 32'h6362FFFF, 8'd36,  1'b1, 1'b1},  // R7 just enough
        '{10'h07F, 32'h00000000, 8'd40,  1'b1, 1'b0},  // R5 offset past end
        '{10'h184, 32'h6362FFFF, 8'd40,  1'b0, 1'b0},  // R7 no anchor
        '{10'h07F, 32'hC0BFFFFF, 8'd130, 1'b1, 1'b1},  // R5 offset 127
        '{10'h20A, 32'h4D4C4B4A, 8'd13,  1'b1, 1'b0},  // R7 32-bit short
        '{10'h20A, 32'h4D4C4B4A, 8'd14,  1'b1, 1'b1}   // R3 32-bit exact
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic           cfg_sel = 1'b0;
    logic [2:0]     cfg_idx = '0;
    logic [31:0]    cfg_wdata = '0;
    logic           rx_valid = 1'b0;
    logic [7:0]     rx_data = '0;
    logic           rx_sof = 1'b0;
    logic           rx_eof = 1'b0;
    logic           anc_l2_stb = 1'b0;
    logic           anc_l3_stb = 1'b0;
    logic           anc_l4_stb = 1'b0;
    logic           match_vld;
    logic [N-1:0]   match_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rfc_field_cmp #(.N_ENTRIES(N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_idx    (cfg_idx),
        .cfg_wdata  (cfg_wdata),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_sof     (rx_sof),
        .rx_eof     (rx_eof),
        .anc_l2_stb (anc_l2_stb),
        .anc_l3_stb (anc_l3_stb),
        .anc_l4_stb (anc_l4_stb),
        .match_vld  (match_vld),
        .match_vec  (match_vec)
    );

    function automatic string tv_tag(input int i);
        case (i)
            0, 1, 2, 3:    return "R2";
            4, 5, 15:      return "R3";
            6, 7, 8:       return "R4";
            11, 13:        return "R5";
            default:       return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    // Send one frame; a position of -1 means that strobe is absent.
    task automatic send(input int len, input int l2a, input int l2b, input int l3,
                        input int l4, input bit gap, input int flip);
        for (int p = 0; p < len; p++) begin
            @(negedge clk);
            rx_valid   = 1'b1;
            rx_data    = 8'(p + 'h40) ^ ((p == flip) ? 8'hFF : 8'h00);
            rx_sof     = (p == 0);
            rx_eof     = (p == len - 1);
            anc_l2_stb = (p == l2a) || (p == l2b);
            anc_l3_stb = (p == l3);
            anc_l4_stb = (p == l4);
            if (gap && p < len - 1) begin
                @(negedge clk);
                rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
                anc_l2_stb = 1'b0; anc_l3_stb = 1'b0; anc_l4_stb = 1'b0;
                rx_data = 8'hEE;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        anc_l2_stb = 1'b0; anc_l3_stb = 1'b0; anc_l4_stb = 1'b0;
    endtask

    // Sample at the falling edge after the end byte, then one cycle later.
    task automatic result(input string tag, input int bit_i, input logic exp);
        check({tag, " vld"}, {31'b0, match_vld}, 32'd1);
        check(tag, {31'b0, match_vec[bit_i]}, {31'b0, exp});
        @(negedge clk);
        check({tag, " pulse end R9"}, {31'b0, match_vld}, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R9 reset vld", {31'b0, match_vld}, 32'd0);
        check("R9 reset vec", {24'b0, match_vec}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset-state entries match any frame of two bytes or more.
        send(2, -1, -1, -1, -1, 1'b0, -1);
        check("R1 defaults vld", {31'b0, match_vld}, 32'd1);
        check("R1 defaults all entries", {24'b0, match_vec}, 32'h000000FF);
        @(negedge clk);
        // R7: a single-byte frame cannot fill any window.
        send(1, -1, -1, -1, -1, 1'b0, -1);
        check("R7 one-byte vld", {31'b0, match_vld}, 32'd1);
        check("R7 one-byte frame", {24'b0, match_vec}, 32'd0);
        @(negedge clk);

        // Table walk: entry i%N takes each vector.
        for (int i = 0; i < 16; i++) begin
            wr(3'(i % N), 1'b1, {22'b0, TV[i].ctrl});
            wr(3'(i % N), 1'b0, TV[i].val);
            if (TV[i].anc) send(int'(TV[i].len), 14, -1, 20, 30, 1'b0, -1);
            else           send(int'(TV[i].len), -1, -1, -1, -1, 1'b0, -1);
            result(tv_tag(i), i % N, TV[i].exp);
        end

        // R11: idle cycles between bytes do not move the window.
        wr(3'd0, 1'b1, 32'h0000020A);
        wr(3'd0, 1'b0, 32'h4D4C4B4A);
        send(40, 14, -1, 20, 30, 1'b1, -1);
        result("R11 gaps", 0, 1'b1);

        // R6: a repeated L2 strobe at byte 18 must not re-anchor.
        wr(3'd0, 1'b1, 32'h00000082);
        wr(3'd0, 1'b0, 32'h5150FFFF);
        send(40, 14, 18, 20, 30, 1'b0, -1);
        result("R6 first strobe", 0, 1'b1);

        // R8: a mismatch or truncation in one frame does not carry over.
        wr(3'd0, 1'b1, 32'h00000200);
        wr(3'd0, 1'b0, 32'h43424140);
        send(40, 14, -1, 20, 30, 1'b0, 0);
        result("R8 corrupt frame", 0, 1'b0);
        send(40, 14, -1, 20, 30, 1'b0, -1);
        result("R8 clean after corrupt", 0, 1'b1);
        send(2, -1, -1, -1, -1, 1'b0, -1);
        result("R8 truncated", 0, 1'b0);
        send(4, -1, -1, -1, -1, 1'b0, -1);
        result("R8 after truncated", 0, 1'b1);

        // R10: entries evaluate side by side on one frame.
        wr(3'd1, 1'b1, 32'h00000000);
        wr(3'd1, 1'b0, 32'h4140FFFF);
        wr(3'd2, 1'b1, 32'h00000000);
        wr(3'd2, 1'b0, 32'h4240FFFF);
        send(40, 14, -1, 20, 30, 1'b0, -1);
        check("R10 entry1", {31'b0, match_vec[1]}, 32'd1);
        check("R10 entry2", {31'b0, match_vec[2]}, 32'd0);
        check("R10 entry0", {31'b0, match_vec[0]}, 32'd1);

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule